// File: doc/BRIEF.md
# Halt mode wake-up controller

This block sequences the deepest sleep state of a small microcontroller. When the CPU executes its halt instruction and the oscillator-interrupt-enable flag is clear, the controller turns the main oscillator off, stalls the CPU, closes the peripheral clock gate and forces the interrupt mask field to its enabled code. The block then waits for one of two events: an enabled wake interrupt, or a reset.

On a wake event the oscillator enable rises at once. The CPU stays stalled while a counter measures a stabilization window of 256 or 4096 cycles, chosen by an option input. When the window ends, the block gives a single-cycle resume pulse. With that pulse comes a flag that tells the core to fetch the reset vector or to service the interrupt. A watchdog-halt option turns a halt issued while the watchdog runs into a watchdog reset request, and in that case the block does not halt.

Top module: `halt_wake_ctrl`

## Requirements
- R1: With `osc_irq_en`=0, `wdg_en`=0 and no `ext_rst`, a `halt_exec` strobe in the running state puts the block in halt from the next cycle: `osc_en`=0 and `cpu_stall`=1.
- R2: A `halt_exec` strobe while `osc_irq_en`=1 is ignored. On the next cycle `cpu_stall`=0, `osc_en`=1 and `periph_clk_en`=1.
- R3: While halted, `osc_en`=0, `periph_clk_en`=0 and `cpu_stall`=1. These hold for as long as neither `wake_irq` nor `ext_rst` is asserted.
- R4: When `wake_irq`=1 in halt, `osc_en` returns to 1 on the next cycle and `cpu_stall` stays 1.
- R5: After a wake event, `cpu_stall`=1 and `osc_en`=1 for exactly 256 cycles if `long_delay` was 0 at the wake event, or for exactly 4096 cycles if it was 1. The resume cycle follows.
- R6: `resume` is a one-cycle pulse with `cpu_stall`=0 in that cycle. `resume_vec` is 0 (service the interrupt) after an interrupt wake and 1 (fetch the reset vector) after a reset.
- R7: In the first halted cycle `mask_force`=1 for one cycle with `mask_val`=2'b10 (interrupts enabled). At all other times `mask_force`=0 and `mask_val`=2'b00.
- R8: If `wake_irq` is already high when halt is entered, the block stays halted for exactly one cycle and then starts stabilization.
- R9: With `wdg_en`=1 and `wdg_halt_rst`=1, a valid halt strobe gives a one-cycle `wdg_rst_req` on the next cycle and the block does not halt. With `wdg_halt_rst`=0 the block halts normally.
- R10: `ext_rst`=1 in any state restarts stabilization from zero on the next cycle, and the resume that follows carries `resume_vec`=1.
- R11: While `rst_n`=0 at a clock edge, the block returns to running: `osc_en`=1, `cpu_stall`=0, `periph_clk_en`=1, and `resume`, `mask_force` and `wdg_rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, running whenever the oscillator is enabled |
| rst_n | input | 1 | Synchronous active-low block reset |
| halt_exec | input | 1 | One-cycle strobe: the halt instruction executed |
| osc_irq_en | input | 1 | Oscillator-interrupt-enable flag; halt is refused while 1 |
| wake_irq | input | 1 | Enabled wake interrupt request (level) |
| ext_rst | input | 1 | Reset event that wakes or restarts the sequence |
| wdg_en | input | 1 | Watchdog running |
| wdg_halt_rst | input | 1 | Option: 1 = halt with watchdog running gives a watchdog reset |
| long_delay | input | 1 | Option: 0 = 256-cycle, 1 = 4096-cycle stabilization |
| osc_en | output | 1 | Main oscillator enable |
| cpu_stall | output | 1 | Holds the CPU |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| mask_force | output | 1 | Strobe: load `mask_val` into the interrupt mask field |
| mask_val | output | 2 | Value forced into the mask field (2'b10 while strobing) |
| wdg_rst_req | output | 1 | Watchdog reset request pulse |
| resume | output | 1 | One-cycle resume pulse to the CPU |
| resume_vec | output | 1 | With `resume`: 1 = fetch reset vector, 0 = service interrupt |

## Verification
The bench counts the stalled cycles with the oscillator running between the wake and the resume, for both delay options. A design with a counter off by one, or one that samples the delay option late, gives 255, 257 or the wrong window. A reset injected part way through stabilization must restart the count and flip the resume flag to the reset-vector path; a design that keeps counting resumes early and would serve the interrupt. The bench also enters halt with an interrupt already pending, where a design that misses the level stays asleep. A halt with the watchdog option set must give only a reset request and no halt, while the same strobe with the flag raised must leave every output untouched.

// File: rtl/halt_wake_pkg.sv
// Shared types for the halt wake-up controller.
// Assumes nothing beyond a single clock domain.
package halt_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALTED = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } hw_state_e;

    localparam logic [1:0] MASK_ENABLED = 2'b10;
endpackage

// File: rtl/hw_stab_counter.sv
// Oscillator stabilization counter.
// Clears on a wake event and latches the delay option at that moment. While
// enabled, it counts and reports done in the cycle the count reaches the
// selected length minus one, so the window is exactly the selected length.
// Assumes clk is the restarted oscillator clock.
module hw_stab_counter #(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic long_sel,
    output logic done
);
    localparam int CNT_W = $clog2(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             sel_q;

    // Counter register and latched delay selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            sel_q <= long_sel;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Done when the selected last count is reached.
    always_comb begin
        done = run && (cnt_q == (sel_q ? LONG_LAST : SHORT_LAST));
    end
endmodule

// File: rtl/hw_fsm.sv
// Halt sequencing state machine: RUN, HALTED, STABILIZE, RESUME.
// A reset event overrides every state and restarts stabilization on the
// reset-vector path. Registered pulses for the mask load and the watchdog
// request. Assumes halt_exec is a one-cycle strobe.
module hw_fsm
    import halt_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_exec,
    input  logic      osc_irq_en,
    input  logic      wake_irq,
    input  logic      ext_rst,
    input  logic      wdg_en,
    input  logic      wdg_halt_rst,
    input  logic      cnt_done,
    output hw_state_e state,
    output logic      cause_rst,
    output logic      cnt_clr,
    output logic      mask_pulse,
    output logic      wdg_pulse
);
    hw_state_e st_q, st_d;
    logic      cause_q, cause_d;
    logic      mask_q, wdg_q;
    logic      halt_ok, wdg_block;

    assign halt_ok   = halt_exec && !osc_irq_en;
    assign wdg_block = wdg_en && wdg_halt_rst;

    // Next-state, counter clear and wake cause selection.
    always_comb begin
        st_d    = st_q;
        cause_d = cause_q;
        cnt_clr = 1'b0;
        if (ext_rst) begin
            st_d    = ST_STAB;
            cause_d = 1'b1;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_RUN:    if (halt_ok && !wdg_block) st_d = ST_HALTED;
                ST_HALTED: if (wake_irq) begin
                               st_d    = ST_STAB;
                               cause_d = 1'b0;
                               cnt_clr = 1'b1;
                           end
                ST_STAB:   if (cnt_done) st_d = ST_RESUME;
                ST_RESUME: st_d = ST_RUN;
                default:   st_d = ST_RUN;
            endcase
        end
    end

    // State, cause and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cause_q <= 1'b0;
            mask_q  <= 1'b0;
            wdg_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cause_q <= cause_d;
            mask_q  <= (st_q != ST_HALTED) && (st_d == ST_HALTED);
            wdg_q   <= (st_q == ST_RUN) && !ext_rst && halt_ok && wdg_block;
        end
    end

    assign state      = st_q;
    assign cause_rst  = cause_q;
    assign mask_pulse = mask_q;
    assign wdg_pulse  = wdg_q;
endmodule

// File: rtl/halt_wake_ctrl.sv
// Top of the halt wake-up controller: state machine plus stabilization
// counter, with the output decode from the registered state.
// Assumes the static option inputs are stable around a wake event.
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_exec,
    input  logic       osc_irq_en,
    input  logic       wake_irq,
    input  logic       ext_rst,
    input  logic       wdg_en,
    input  logic       wdg_halt_rst,
    input  logic       long_delay,
    output logic       osc_en,
    output logic       cpu_stall,
    output logic       periph_clk_en,
    output logic       mask_force,
    output logic [1:0] mask_val,
    output logic       wdg_rst_req,
    output logic       resume,
    output logic       resume_vec
);
    hw_state_e state;
    logic      cause_rst, cnt_clr, cnt_done, mask_pulse;

    hw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_exec    (halt_exec),
        .osc_irq_en   (osc_irq_en),
        .wake_irq     (wake_irq),
        .ext_rst      (ext_rst),
        .wdg_en       (wdg_en),
        .wdg_halt_rst (wdg_halt_rst),
        .cnt_done     (cnt_done),
        .state        (state),
        .cause_rst    (cause_rst),
        .cnt_clr      (cnt_clr),
        .mask_pulse   (mask_pulse),
        .wdg_pulse    (wdg_rst_req)
    );

    hw_stab_counter #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .run      (state == ST_STAB),
        .long_sel (long_delay),
        .done     (cnt_done)
    );

    // Output decode from the registered state.
    always_comb begin
        osc_en        = (state != ST_HALTED);
        cpu_stall     = (state == ST_HALTED) || (state == ST_STAB);
        periph_clk_en = (state == ST_RUN) || (state == ST_RESUME);
        resume        = (state == ST_RESUME);
        resume_vec    = cause_rst;
        mask_force    = mask_pulse;
        mask_val      = mask_pulse ? MASK_ENABLED : 2'b00;
    end
endmodule

// File: rtl/hw_chk.sv
// Port-level temporal checks for halt_wake_ctrl, attached by bind.
module hw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_exec,
    input logic       osc_irq_en,
    input logic       wake_irq,
    input logic       ext_rst,
    input logic       wdg_en,
    input logic       wdg_halt_rst,
    input logic       osc_en,
    input logic       cpu_stall,
    input logic       periph_clk_en,
    input logic       mask_force,
    input logic [1:0] mask_val,
    input logic       wdg_rst_req,
    input logic       resume
);
    assert_halt_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clk_en && !resume && halt_exec && !osc_irq_en && !wdg_en && !ext_rst
        |=> !osc_en && cpu_stall);

    assert_halt_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clk_en && !resume && halt_exec && osc_irq_en && !ext_rst
        |=> !cpu_stall && osc_en);

    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && !wake_irq && !ext_rst |=> !osc_en && !periph_clk_en);

    assert_wake_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && wake_irq && !ext_rst |=> osc_en && cpu_stall);

    assert_resume_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume && !ext_rst |=> !resume && !cpu_stall);

    assert_mask_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_force |-> mask_val == 2'b10 && !osc_en);

    assert_pending_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_force && wake_irq && !ext_rst |=> osc_en && cpu_stall);

    assert_wdg_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |-> $past(halt_exec && !osc_irq_en && wdg_en && wdg_halt_rst) && !cpu_stall);

    assert_reset_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> osc_en && cpu_stall && !resume);
endmodule

bind halt_wake_ctrl hw_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_exec     (halt_exec),
    .osc_irq_en    (osc_irq_en),
    .wake_irq      (wake_irq),
    .ext_rst       (ext_rst),
    .wdg_en        (wdg_en),
    .wdg_halt_rst  (wdg_halt_rst),
    .osc_en        (osc_en),
    .cpu_stall     (cpu_stall),
    .periph_clk_en (periph_clk_en),
    .mask_force    (mask_force),
    .mask_val      (mask_val),
    .wdg_rst_req   (wdg_rst_req),
    .resume        (resume)
);

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_N    = 256;
    localparam int LONG_N     = 4096;
    localparam int WDOG_CYC   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 1'b0, osc_irq_en = 1'b0, wake_irq = 1'b0, ext_rst = 1'b0;
    logic wdg_en = 1'b0, wdg_halt_rst = 1'b0, long_delay = 1'b0;
    logic osc_en, cpu_stall, periph_clk_en, mask_force, wdg_rst_req, resume, resume_vec;
    logic [1:0] mask_val;

    int n_chk = 0;
    int n_bad = 0;

    halt_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .osc_irq_en(osc_irq_en),
        .wake_irq(wake_irq), .ext_rst(ext_rst), .wdg_en(wdg_en),
        .wdg_halt_rst(wdg_halt_rst), .long_delay(long_delay), .osc_en(osc_en),
        .cpu_stall(cpu_stall), .periph_clk_en(periph_clk_en), .mask_force(mask_force),
        .mask_val(mask_val), .wdg_rst_req(wdg_rst_req), .resume(resume),
        .resume_vec(resume_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R11 osc_en", osc_en, 1);
        chk("R11 cpu_stall", cpu_stall, 0);
        chk("R11 periph_clk_en", periph_clk_en, 1);
        chk("R11 pulses", {resume, mask_force, wdg_rst_req}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    // R2: halt refused while the oscillator-interrupt flag is set.
    task automatic t_ignored();
        osc_irq_en = 1'b1; halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0; osc_irq_en = 1'b0;
        chk("R2 cpu_stall", cpu_stall, 0);
        chk("R2 osc_en", osc_en, 1);
        chk("R2 periph_clk_en", periph_clk_en, 1);
        chk("R2 mask_force", mask_force, 0);
    endtask

    // R1/R3/R7: enter halt and stay there.
    task automatic t_enter();
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        chk("R1 osc_en", osc_en, 0);
        chk("R1 cpu_stall", cpu_stall, 1);
        chk("R7 mask_force", mask_force, 1);
        chk("R7 mask_val", mask_val, 2);
        for (int i = 0; i < 5; i++) tick();
        chk("R3 osc_en", osc_en, 0);
        chk("R3 periph_clk_en", periph_clk_en, 0);
        chk("R3 cpu_stall", cpu_stall, 1);
        chk("R7 mask_force low", mask_force, 0);
        chk("R7 mask_val low", mask_val, 0);
    endtask

    // R5/R6: at the first stabilization cycle, count the window and check resume.
    task automatic count_stab(input int exp_n, input int exp_vec, input string tag);
        int n = 1;
        tick();
        while (!resume && n < 10000) begin
            if (!(osc_en && cpu_stall)) break;
            n++;
            tick();
        end
        chk({tag, " R5 window"}, n, exp_n);
        chk({tag, " R6 resume"}, resume, 1);
        chk({tag, " R6 stall low"}, cpu_stall, 0);
        chk({tag, " R6 resume_vec"}, resume_vec, exp_vec);
        tick();
        chk({tag, " R6 one pulse"}, resume, 0);
    endtask

    // R4: wake from halt by interrupt.
    task automatic t_wake_irq(input logic lng, input string tag);
        long_delay = lng; wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        chk({tag, " R4 osc_en"}, osc_en, 1);
        chk({tag, " R4 cpu_stall"}, cpu_stall, 1);
        count_stab(lng ? LONG_N : SHORT_N, 0, tag);
        long_delay = 1'b0;
    endtask

    // R8: interrupt already pending at halt entry.
    task automatic t_pending();
        halt_exec = 1'b1; wake_irq = 1'b1;
        tick();
        halt_exec = 1'b0;
        chk("R8 halted one cycle", osc_en, 0);
        tick();
        wake_irq = 1'b0;
        chk("R8 osc back", osc_en, 1);
        count_stab(SHORT_N, 0, "R8");
    endtask

    // R9: watchdog option turns halt into a reset request.
    task automatic t_wdg();
        wdg_en = 1'b1; wdg_halt_rst = 1'b1; halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        chk("R9 wdg_rst_req", wdg_rst_req, 1);
        chk("R9 no halt", osc_en, 1);
        chk("R9 no stall", cpu_stall, 0);
        tick();
        chk("R9 pulse ends", wdg_rst_req, 0);
        wdg_halt_rst = 1'b0; halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        chk("R9 halts with option 0", osc_en, 0);
        chk("R9 no request option 0", wdg_rst_req, 0);
        wdg_en = 1'b0;
        t_wake_irq(1'b0, "R9 wake");
    endtask

    // R10: reset from halt, mid-stabilization, and from run.
    task automatic t_ext_reset();
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        tick();
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        chk("R10 from halt osc", osc_en, 1);
        count_stab(SHORT_N, 1, "R10 halt");
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        for (int i = 0; i < 100; i++) tick();
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        count_stab(SHORT_N, 1, "R10 mid");
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        chk("R10 from run stall", cpu_stall, 1);
        count_stab(SHORT_N, 1, "R10 run");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ignored();
                t_enter();
                t_wake_irq(1'b0, "short");
                t_enter();
                t_wake_irq(1'b1, "long");
                t_pending();
                t_wdg();
                t_ext_reset();
            end
            begin
                repeat (WDOG_CYC) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule